// File: doc/BRIEF.md
# Common-Area Program Bank Mapper

This block lets a controller with a 16-bit address bus reach a 512 kB external program store built from sixteen pages of 32 kB each. It sits beside the CPU bus and drives the four memory address lines above the CPU's own, A15 up to A18. The lower half of the CPU map (0000h to 7FFFh) is always the common page, where the interrupt vectors and bank-switch code live. The upper half (8000h to FFFFh) shows whichever page is currently selected.

The page number is loaded by software with an ordinary data-memory write into a 32-byte window at the very top of the map. Only the upper address bits are decoded, so every address in that window reaches the same bank register. Any access to the lower half drives the upper lines to zero for that access only. The stored page is not touched, so it reappears as soon as the CPU returns to the upper half. A build-time option replaces the register with a 4-bit port input that names the page directly. The lower-half override still applies in that option.

Top module: `prog_page_mapper`

## Requirements
- R1: After reset, and until the first loading write, the stored bank reads 0 on `bank_held`. `mem_hi` is 0 for every address.
- R2: In register mode, a clock edge that sees `wr_qual` high and `cpu_addr` in FFE0h..FFFFh stores `cpu_wdata[3:0]`. The new value is visible on `bank_held` after that edge.
- R3: Every address in the window loads the register, including both ends FFE0h and FFFFh and addresses inside it.
- R4: A qualified write to any address outside the window (for example FFDFh, 8000h or 7FFFh) leaves the stored bank unchanged.
- R5: A window address with `wr_qual` low leaves the stored bank unchanged.
- R6: While `cpu_addr[15]` is 0, `mem_hi` is 4'h0 in the same cycle, whatever bank is stored.
- R7: While `cpu_addr[15]` is 1, `mem_hi` equals the selected bank in the same cycle. Bit 0 drives A15, bit 1 drives A16, bit 2 drives A17 and bit 3 drives A18.
- R8: Accesses to the common half do not alter the stored bank. When the address returns to the upper half, the previous bank reappears on `mem_hi` with no new write.
- R9: Bits of `cpu_wdata` above bit 3 have no effect on the stored bank.
- R10: With `PORT_MODE` = 1, `bank_held` mirrors `port_bank`. Upper-half accesses drive `port_bank` onto `mem_hi` and lower-half accesses drive 0. Writes to the window have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the bank register loads on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the bank register |
| cpu_addr | input | 16 | CPU address of the current access |
| cpu_wdata | input | 8 | CPU write data |
| wr_qual | input | 1 | Qualified data-memory write strobe, active high |
| port_bank | input | 4 | Bank number used in port mode |
| mem_hi | output | 4 | Memory address lines A15 (bit 0) to A18 (bit 3) |
| bank_held | output | 4 | Currently stored (or, in port mode, supplied) bank |

## Verification
The properties assume that `wr_qual` is already qualified and only ever means a data-memory write. They also assume that address and data are steady around the rising edge. The load and hold properties compare one cycle against the previous one, with no other source of change. The bench changes every input only on the falling clock edge and holds it for a full cycle. Each write it issues is one clock long, so each edge sees at most one unambiguous write. A second instance built in port mode shares the same bus. It checks that the window writes which load the first instance leave the port-mode bank alone.

// File: rtl/pm_pkg.sv
package pm_pkg;
    localparam int BANK_W = 4;
    typedef logic [BANK_W-1:0] bank_t;
    typedef enum logic { SRC_LATCH = 1'b0, SRC_PORT = 1'b1 } src_e;
endpackage

// File: rtl/pm_window_decode.sv
module pm_window_decode #(
    parameter int ADDR_W  = 16,
    parameter int WIN_LSB = 5
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              win_hit,
    output logic              common_hit
);
    localparam int TAG_W = ADDR_W - WIN_LSB;

    logic [TAG_W-1:0] tag;
    logic             unused_low;

    assign tag        = addr[ADDR_W-1:WIN_LSB];
    assign win_hit    = &tag;
    assign common_hit = ~addr[ADDR_W-1];
    assign unused_low = ^addr[WIN_LSB-1:0];
endmodule

// File: rtl/pm_bank_store.sv
module pm_bank_store
    import pm_pkg::*;
#(
    parameter int   DATA_W = 8,
    parameter src_e SRC    = SRC_LATCH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  bank_t             port_bank,
    output bank_t             bank_q
);
    generate
        if (SRC == SRC_LATCH) begin : g_latch
            bank_t bank_r;
            logic  unused_in;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    bank_r <= '0;
                else if (load)
                    bank_r <= wdata[BANK_W-1:0];
            end

            assign bank_q    = bank_r;
            assign unused_in = ^{port_bank, wdata[DATA_W-1:BANK_W]};
        end else begin : g_port
            logic unused_in;

            assign bank_q    = port_bank;
            assign unused_in = ^{clk, rst_n, load, wdata};
        end
    endgenerate
endmodule

// File: rtl/pm_addr_drive.sv
module pm_addr_drive
    import pm_pkg::*;
(
    input  logic  common_hit,
    input  bank_t bank,
    output bank_t mem_hi
);
    generate
        for (genvar i = 0; i < BANK_W; i++) begin : g_line
            assign mem_hi[i] = bank[i] & ~common_hit;
        end
    endgenerate
endmodule

// File: rtl/prog_page_mapper.sv
module prog_page_mapper
    import pm_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int WIN_LSB   = 5,
    parameter bit PORT_MODE = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              wr_qual,
    input  logic [BANK_W-1:0] port_bank,
    output logic [BANK_W-1:0] mem_hi,
    output logic [BANK_W-1:0] bank_held
);
    localparam src_e BANK_SRC = src_e'(PORT_MODE);

    logic  win_hit;
    logic  common_hit;
    logic  load;
    bank_t bank_sel;

    pm_window_decode #(.ADDR_W(ADDR_W), .WIN_LSB(WIN_LSB)) u_dec (
        .addr       (cpu_addr),
        .win_hit    (win_hit),
        .common_hit (common_hit)
    );

    assign load = wr_qual & win_hit;

    pm_bank_store #(.DATA_W(DATA_W), .SRC(BANK_SRC)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .wdata     (cpu_wdata),
        .port_bank (port_bank),
        .bank_q    (bank_sel)
    );

    pm_addr_drive u_drive (
        .common_hit (common_hit),
        .bank       (bank_sel),
        .mem_hi     (mem_hi)
    );

    assign bank_held = bank_sel;
endmodule

// File: rtl/pm_checker.sv
module pm_checker #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 8,
    parameter int WIN_LSB   = 5,
    parameter bit PORT_MODE = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic              wr_qual,
    input logic [3:0]        port_bank,
    input logic [3:0]        mem_hi,
    input logic [3:0]        bank_held
);
    localparam logic [ADDR_W-1:0] WIN_BASE = {ADDR_W{1'b1}} << WIN_LSB;

    logic in_win;
    assign in_win = (cpu_addr >= WIN_BASE);

    // R6
    a_r6_common_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[ADDR_W-1] |-> mem_hi == 4'h0);

    generate
        if (!PORT_MODE) begin : g_latch_chk
            // R1
            a_r1_reset_clear: assert property (@(posedge clk)
                $rose(rst_n) |-> bank_held == 4'h0);
            // R2
            a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
                wr_qual && in_win |=> bank_held == $past(cpu_wdata[3:0]));
            // R4, R5, R8
            a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_qual && in_win) |=> $stable(bank_held));
            // R7
            a_r7_paged: assert property (@(posedge clk) disable iff (!rst_n)
                cpu_addr[ADDR_W-1] |-> mem_hi == bank_held);
        end else begin : g_port_chk
            // R10
            a_r10_port_drive: assert property (@(posedge clk) disable iff (!rst_n)
                cpu_addr[ADDR_W-1] |-> mem_hi == port_bank);
            a_r10_port_mirror: assert property (@(posedge clk) disable iff (!rst_n)
                bank_held == port_bank);
        end
    endgenerate
endmodule

bind prog_page_mapper pm_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LSB(WIN_LSB), .PORT_MODE(PORT_MODE)
) u_pm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .wr_qual   (wr_qual),
    .port_bank (port_bank),
    .mem_hi    (mem_hi),
    .bank_held (bank_held)
);

// File: tb/test_prog_page_mapper.sv
`timescale 1ns/1ps
module test_prog_page_mapper;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        wr_qual = 1'b0;
    logic [3:0]  port_bank = 4'h0;
    logic [3:0]  mem_hi, bank_held;
    logic [3:0]  p_mem_hi, p_bank_held;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    prog_page_mapper i_prog_page_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .wr_qual(wr_qual), .port_bank(port_bank), .mem_hi(mem_hi), .bank_held(bank_held)
    );

    prog_page_mapper #(.PORT_MODE(1'b1)) i_prog_page_mapper_port (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .wr_qual(wr_qual), .port_bank(port_bank), .mem_hi(p_mem_hi), .bank_held(p_bank_held)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one-cycle write: driven at falling edge, captured at next rising edge
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        wr_qual   = 1'b1;
        @(negedge clk);
        wr_qual   = 1'b0;
        cpu_addr  = 16'h9000;
        #1;
    endtask

    task automatic set_addr(input logic [15:0] a);
        @(negedge clk);
        cpu_addr = a;
        #1;
    endtask

    task automatic t_reset;
        check("R1 bank after reset", bank_held, 4'h0);
        set_addr(16'hC000);
        check("R1 paged lines after reset", mem_hi, 4'h0);
        set_addr(16'h0000);
        check("R1 reset vector lines", mem_hi, 4'h0);
    endtask

    task automatic t_load_edges;
        bus_write(16'hFFE0, 8'h05);
        check("R3 load at FFE0", bank_held, 4'h5);
        check("R7 paged lines bank 5", mem_hi, 4'h5);
        bus_write(16'hFFFF, 8'h0A);
        check("R3 load at FFFF", bank_held, 4'hA);
        bus_write(16'hFFF3, 8'h0F);
        check("R2 load mid window", bank_held, 4'hF);
        check("R7 all lines high", mem_hi, 4'hF);
        bus_write(16'hFFE7, 8'h00);
        check("R2 load zero", bank_held, 4'h0);
    endtask

    task automatic t_outside;
        bus_write(16'hFFE0, 8'h06);
        bus_write(16'hFFDF, 8'h09);
        check("R4 write FFDF ignored", bank_held, 4'h6);
        bus_write(16'h8000, 8'h03);
        check("R4 write 8000 ignored", bank_held, 4'h6);
        bus_write(16'h7FFF, 8'h0C);
        check("R4 write 7FFF ignored", bank_held, 4'h6);
    endtask

    task automatic t_no_strobe;
        @(negedge clk);
        cpu_addr  = 16'hFFF0;
        cpu_wdata = 8'h0B;
        @(negedge clk);
        @(negedge clk);
        check("R5 no strobe no load", bank_held, 4'h6);
    endtask

    task automatic t_override;
        bus_write(16'hFFE0, 8'h09);
        set_addr(16'h0003);
        check("R6 common lines zero", mem_hi, 4'h0);
        check("R8 bank kept in common", bank_held, 4'h9);
        set_addr(16'h7FFF);
        check("R6 top of common zero", mem_hi, 4'h0);
        set_addr(16'h8000);
        check("R8 bank returns", mem_hi, 4'h9);
        set_addr(16'hABCD);
        check("R7 paged lines bank 9", mem_hi, 4'h9);
    endtask

    task automatic t_upper_data;
        bus_write(16'hFFE4, 8'hF2);
        check("R9 upper data ignored", bank_held, 4'h2);
        bus_write(16'hFFE4, 8'h7C);
        check("R9 upper data ignored again", bank_held, 4'hC);
    endtask

    task automatic t_port_mode;
        @(negedge clk);
        port_bank = 4'hA;
        cpu_addr  = 16'h9000;
        #1;
        check("R10 port paged", p_mem_hi, 4'hA);
        check("R10 port mirror", p_bank_held, 4'hA);
        set_addr(16'h1000);
        check("R10 port common zero", p_mem_hi, 4'h0);
        bus_write(16'hFFE0, 8'h03);
        check("R10 port ignores write", p_bank_held, 4'hA);
        check("R10 port paged after write", p_mem_hi, 4'hA);
        check("R2 latch instance loaded", bank_held, 4'h3);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        t_reset_pre();
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        t_reset;
        t_load_edges;
        t_outside;
        t_no_strobe;
        t_override;
        t_upper_data;
        t_port_mode;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    task automatic t_reset_pre;
        check("R1 bank during reset", bank_held, 4'h0);
    endtask
endmodule